// File: doc/BRIEF.md
# I2C Controller Status Flag Logic

This block holds the status byte of a byte-oriented I2C controller that can work as bus master or as addressed slave. It samples the raw SCL and SDA lines through a short synchroniser to find START and STOP conditions and arbitration faults. It also takes strobes from the neighbouring shift engine: a received bit, the first byte after a START, and the end of a byte (the falling edge of the last SCL, ACK clock included). From these it keeps the flags that software reads.

CPU writes come in two kinds. A write to the data shift register releases a pending byte and clears the per-byte flags. A status write sets the mode and control bits in the upper nibble. While a byte is pending, the block asks the bus driver to hold SCL low. It also raises a one-cycle interrupt request when the pending flag becomes active. A request to generate a new START is only passed on while the bus is free.

Top module: `i2c_stat_flags`

Status byte layout:

| Bit | Flag | Access |
|-----|------|--------|
| 0 | last received bit | read-only |
| 1 | general call | read-only |
| 2 | address matched | read-only |
| 3 | arbitration lost | read-only |
| 4 | no byte pending (active low) | read/write |
| 5 | bus busy | read/write |
| 6 | transmit | read/write |
| 7 | master | read/write |

## Requirements
- R1: Bit 0 takes `rx_bit_i` on every `rx_bit_stb_i`. On the ACK clock this reads 0 for acknowledged and 1 for not acknowledged. A write to the data shift register clears bit 0 to 0.
- R2: Bit 1 sets when `addr_stb_i` delivers the byte 0x00 while the device is slave (bit 7 = 0). It clears on a START or a STOP seen on the bus.
- R3: With `ten_bit_i`=0, bit 2 sets on a slave `addr_stb_i` in two cases: when `rx_byte_i[7:1]` equals `own_addr_i[7:1]`, or when the byte is 0x00.
- R4: With `ten_bit_i`=1, bit 2 sets on a slave `addr_stb_i` only when all 8 bits of `rx_byte_i` equal `own_addr_i`. A write to the data shift register clears bit 2.
- R5: Arbitration is lost when SCL rises while all of the following hold: master (bit 7), transmit (bit 6), `drive_high_i`=1, and SDA low. On that edge bit 3 sets and bit 6 clears. Bit 7 clears at the next `byte_done_i`. A write to the data shift register clears bit 3.
- R6: As master, `byte_done_i` drives bit 4 to 0. `irq_o` is high for exactly one cycle, in the cycle after bit 4 falls.
- R7: `scl_hold_o` is 1 exactly while the block is enabled and bit 4 is 0.
- R8: Bit 4 returns to 1 on a write to the data shift register, when `enable_i` is 0, and at reset. The reset value of the status byte is 0x10.
- R9: As slave, `byte_done_i` on the address byte drives bit 4 to 0 in two cases: when bit 2 is set, or when `every_addr_i`=1. On later bytes it does so only if this device was addressed since the last START.
- R10: A START sets bit 5 and a STOP clears it. A status write changes bit 5 only while bits 7 and 6 are both 1. `enable_i`=0 forces bit 5 to 0.
- R11: `start_go_o` is 1 in the cycle after `start_req_i` only when bit 5 was 0 and the block is enabled.
- R12: A status write changes bits 7..4 (bit 5 subject to R10) and leaves bits 3..0 unchanged.
- R13: A START or STOP on the raw pins shows in bit 5 on the third rising clock edge after the pin change, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| scl_i | input | 1 | raw SCL line |
| sda_i | input | 1 | raw SDA line |
| enable_i | input | 1 | interface enable |
| every_addr_i | input | 1 | flag every address byte as pending, matched or not |
| ten_bit_i | input | 1 | 10-bit addressing (first byte compare) |
| own_addr_i | input | 8 | own address register |
| addr_stb_i | input | 1 | first byte after START is in `rx_byte_i` |
| rx_byte_i | input | 8 | received byte |
| rx_bit_stb_i | input | 1 | received bit strobe |
| rx_bit_i | input | 1 | received bit value |
| byte_done_i | input | 1 | falling edge of last SCL of a byte |
| drive_high_i | input | 1 | device is releasing SDA high |
| dsr_wr_i | input | 1 | CPU write to data shift register |
| stat_wr_i | input | 1 | CPU write to status register |
| stat_wdata_i | input | 8 | status write data |
| start_req_i | input | 1 | request to generate a START |
| status_o | output | 8 | status byte |
| irq_o | output | 1 | interrupt request pulse |
| scl_hold_o | output | 1 | hold SCL low |
| start_go_o | output | 1 | START request granted |

## Verification
Strobes and CPU writes act on the next rising edge, so the bench drives them on a falling edge and samples the status one falling edge later. Pin changes pass two synchroniser flops and an edge register, so bus-driven flags are due on the third rising edge. The bench checks that the flag has not moved after two edges and has moved after three. `irq_o` is due in the cycle after the pending bit falls, and is sampled in that cycle and in the one that follows. The address comparator is swept over all 256 byte values in both addressing modes, with expected flags worked out arithmetically.

// File: rtl/i2c_sf_pkg.sv
package i2c_sf_pkg;
  localparam int ST_W     = 8;
  localparam int B_LAST   = 0;
  localparam int B_GCALL  = 1;
  localparam int B_HIT    = 2;
  localparam int B_ARB    = 3;
  localparam int B_PEND_N = 4;
  localparam int B_BUSY   = 5;
  localparam int B_XMIT   = 6;
  localparam int B_MASTER = 7;
endpackage

// File: rtl/i2c_sf_sync.sv
module i2c_sf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;
  logic scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      for (int i = STAGES - 1; i > 0; i--) begin
        scl_ff[i] <= scl_ff[i-1];
        sda_ff[i] <= sda_ff[i-1];
      end
      scl_ff[0] <= scl_i;
      sda_ff[0] <= sda_i;
      scl_q     <= scl_s;
      sda_q     <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  // SDA edge while SCL stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_sf_addr.sv
module i2c_sf_addr #(
  parameter int AW = 8
) (
  input  logic [AW-1:0] own_i,
  input  logic [AW-1:0] byte_i,
  input  logic          ten_bit_i,
  output logic          hit_o,
  output logic          gcall_o
);
  logic hit7, hit10;

  assign gcall_o = (byte_i == '0);
  assign hit7    = (byte_i[AW-1:1] == own_i[AW-1:1]) | gcall_o;
  assign hit10   = (byte_i == own_i);
  assign hit_o   = ten_bit_i ? hit10 : hit7;

  always_comb begin
    // R3: a general call always matches in 7-bit mode
    p_gcall_hit_r3: assert (!(gcall_o && !ten_bit_i) || hit_o);
  end
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_sf_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              enable_i,
  input  logic              every_addr_i,
  input  logic              ten_bit_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              addr_stb_i,
  input  logic [ADDR_W-1:0] rx_byte_i,
  input  logic              rx_bit_stb_i,
  input  logic              rx_bit_i,
  input  logic              byte_done_i,
  input  logic              drive_high_i,
  input  logic              dsr_wr_i,
  input  logic              stat_wr_i,
  input  logic [ST_W-1:0]   stat_wdata_i,
  input  logic              start_req_i,
  output logic [ST_W-1:0]   status_o,
  output logic              irq_o,
  output logic              scl_hold_o,
  output logic              start_go_o
);
  logic sda_s, scl_rise, start_det, stop_det;
  logic hit, gcall;

  i2c_sf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_sf_addr #(.AW(ADDR_W)) u_addr (
    .own_i     (own_addr_i),
    .byte_i    (rx_byte_i),
    .ten_bit_i (ten_bit_i),
    .hit_o     (hit),
    .gcall_o   (gcall)
  );

  logic last_q, gcall_q, hit_q, arb_q, pend_n_q, busy_q, xmit_q, master_q;
  logic pend_d1_q, sel_q, addr_ph_q, go_q;
  logic arb_evt, slv_rel, pend_clr, slv_addr;

  assign slv_addr = addr_stb_i & ~master_q;
  assign arb_evt  = master_q & xmit_q & drive_high_i & scl_rise & ~sda_s;
  // slave: address byte releases on match or every_addr, data bytes only when selected
  assign slv_rel  = addr_ph_q ? (every_addr_i | hit_q) : sel_q;
  assign pend_clr = byte_done_i & (master_q | slv_rel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q    <= 1'b0;
      gcall_q   <= 1'b0;
      hit_q     <= 1'b0;
      arb_q     <= 1'b0;
      pend_n_q  <= 1'b1;
      busy_q    <= 1'b0;
      xmit_q    <= 1'b0;
      master_q  <= 1'b0;
      sel_q     <= 1'b0;
      addr_ph_q <= 1'b0;
    end else if (!enable_i) begin
      arb_q     <= 1'b0;
      pend_n_q  <= 1'b1;
      busy_q    <= 1'b0;
      xmit_q    <= 1'b0;
      master_q  <= 1'b0;
      sel_q     <= 1'b0;
      addr_ph_q <= 1'b0;
    end else begin
      if (dsr_wr_i)          last_q <= 1'b0;
      else if (rx_bit_stb_i) last_q <= rx_bit_i;

      if (start_det || stop_det)  gcall_q <= 1'b0;
      else if (slv_addr && gcall) gcall_q <= 1'b1;

      if (dsr_wr_i)             hit_q <= 1'b0;
      else if (slv_addr && hit) hit_q <= 1'b1;

      if (start_det || stop_det) sel_q <= 1'b0;
      else if (slv_addr && hit)  sel_q <= 1'b1;

      if (start_det)        addr_ph_q <= 1'b1;
      else if (byte_done_i) addr_ph_q <= 1'b0;

      if (dsr_wr_i)     arb_q <= 1'b0;
      else if (arb_evt) arb_q <= 1'b1;

      if (arb_evt)        xmit_q <= 1'b0;
      else if (stat_wr_i) xmit_q <= stat_wdata_i[B_XMIT];

      if (byte_done_i && arb_q) master_q <= 1'b0;
      else if (stat_wr_i)       master_q <= stat_wdata_i[B_MASTER];

      if (start_det)                          busy_q <= 1'b1;
      else if (stop_det)                      busy_q <= 1'b0;
      else if (stat_wr_i && master_q && xmit_q) busy_q <= stat_wdata_i[B_BUSY];

      if (dsr_wr_i)       pend_n_q <= 1'b1;
      else if (pend_clr)  pend_n_q <= 1'b0;
      else if (stat_wr_i) pend_n_q <= stat_wdata_i[B_PEND_N];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_d1_q <= 1'b1;
      go_q      <= 1'b0;
    end else begin
      pend_d1_q <= pend_n_q;
      go_q      <= start_req_i & enable_i & ~busy_q;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[B_LAST]   = last_q;
    status_o[B_GCALL]  = gcall_q;
    status_o[B_HIT]    = hit_q;
    status_o[B_ARB]    = arb_q;
    status_o[B_PEND_N] = pend_n_q;
    status_o[B_BUSY]   = busy_q;
    status_o[B_XMIT]   = xmit_q;
    status_o[B_MASTER] = master_q;
  end

  assign irq_o      = pend_d1_q & ~pend_n_q;
  assign scl_hold_o = enable_i & ~pend_n_q;
  assign start_go_o = go_q;

  p_irq_once_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  p_irq_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && enable_i) |-> scl_hold_o);
  p_dsr_rel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsr_wr_i |=> pend_n_q);
  p_off_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!busy_q && pend_n_q));
  p_busy_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && start_det) |=> busy_q);
  p_arb_xmit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arb_q) |-> !xmit_q);
  p_go_free_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_go_o |-> $past(!busy_q));
endmodule

// File: tb/i2c_stat_flags_tb.sv
`timescale 1ns/1ps
module i2c_stat_flags_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl = 1'b1, sda = 1'b1;
  logic enable = 1'b0, every_addr = 1'b0, ten_bit = 1'b0;
  logic [7:0] own_addr = 8'h54;
  logic addr_stb = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic rx_bit_stb = 1'b0, rx_bit = 1'b0, byte_done = 1'b0, drive_high = 1'b0;
  logic dsr_wr = 1'b0, stat_wr = 1'b0;
  logic [7:0] stat_wdata = 8'h00;
  logic start_req = 1'b0;
  logic [7:0] status;
  logic irq, scl_hold, start_go;
  int n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  i2c_stat_flags dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda),
    .enable_i(enable), .every_addr_i(every_addr), .ten_bit_i(ten_bit),
    .own_addr_i(own_addr), .addr_stb_i(addr_stb), .rx_byte_i(rx_byte),
    .rx_bit_stb_i(rx_bit_stb), .rx_bit_i(rx_bit), .byte_done_i(byte_done),
    .drive_high_i(drive_high), .dsr_wr_i(dsr_wr), .stat_wr_i(stat_wr),
    .stat_wdata_i(stat_wdata), .start_req_i(start_req),
    .status_o(status), .irq_o(irq), .scl_hold_o(scl_hold), .start_go_o(start_go)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  // pins reach the flags on the third rising edge
  task automatic bus(input logic c, input logic d);
    scl = c; sda = d;
    repeat (3) cyc();
  endtask

  task automatic dsr_pulse();
    dsr_wr = 1'b1; cyc(); dsr_wr = 1'b0;
  endtask

  task automatic addr_pulse(input logic [7:0] b);
    rx_byte = b; addr_stb = 1'b1; cyc(); addr_stb = 1'b0;
  endtask

  task automatic done_pulse();
    byte_done = 1'b1; cyc(); byte_done = 1'b0;
  endtask

  task automatic swr(input logic [7:0] d);
    stat_wdata = d; stat_wr = 1'b1; cyc(); stat_wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic exp_gc;
    logic exp_hit;
    repeat (3) cyc();
    rst_ni = 1'b1;
    cyc();
    chk("R8 reset status", status, 8'h10);
    chk("R7 reset hold", {7'd0, scl_hold}, 8'h00);
    chk("R6 reset irq", {7'd0, irq}, 8'h00);
    enable = 1'b1;
    cyc();

    // R13 latency and R10 start/stop
    sda = 1'b0;
    repeat (2) cyc();
    chk("R13 busy not before third edge", {7'd0, status[5]}, 8'h00);
    cyc();
    chk("R13 R10 busy after START", {7'd0, status[5]}, 8'h01);
    bus(1'b1, 1'b1);
    chk("R10 busy cleared by STOP", {7'd0, status[5]}, 8'h00);

    // address sweep, both modes
    for (int m = 0; m < 2; m++) begin
      ten_bit  = (m == 1);
      own_addr = (m == 1) ? 8'hF3 : 8'h54;
      exp_gc   = 1'b0;
      for (int b = 0; b < 256; b++) begin
        dsr_pulse();
        addr_pulse(8'(b));
        exp_hit = (m == 1) ? (8'(b) == own_addr)
                           : ((8'(b) >> 1) == (own_addr >> 1)) || (b == 0);
        exp_gc  = exp_gc | (b == 0);
        if (m == 1) chk("R4 10-bit match", {7'd0, status[2]}, {7'd0, exp_hit});
        else        chk("R3 7-bit match",  {7'd0, status[2]}, {7'd0, exp_hit});
        chk("R2 general call", {7'd0, status[1]}, {7'd0, exp_gc});
      end
      dsr_pulse();
      chk("R4 match cleared by data write", {7'd0, status[2]}, 8'h00);
      bus(1'b1, 1'b0);
      chk("R2 general call cleared by START", {7'd0, status[1]}, 8'h00);
      addr_pulse(8'h00);
      chk("R2 general call set", {7'd0, status[1]}, 8'h01);
      bus(1'b1, 1'b1);
      chk("R2 general call cleared by STOP", {7'd0, status[1]}, 8'h00);
    end
    ten_bit = 1'b0; own_addr = 8'h54;
    dsr_pulse();

    // R9 slave release policy, every_addr = 0
    bus(1'b1, 1'b0);
    addr_pulse(8'h10);
    done_pulse();
    chk("R9 unmatched address keeps pending bit", {7'd0, status[4]}, 8'h01);
    chk("R6 no irq on unmatched", {7'd0, irq}, 8'h00);
    bus(1'b1, 1'b1);
    bus(1'b1, 1'b0);
    addr_pulse(8'h55);
    done_pulse();
    chk("R9 matched address releases", {7'd0, status[4]}, 8'h00);
    chk("R6 irq pulse", {7'd0, irq}, 8'h01);
    chk("R7 hold while pending", {7'd0, scl_hold}, 8'h01);
    cyc();
    chk("R6 irq single cycle", {7'd0, irq}, 8'h00);
    dsr_pulse();
    chk("R8 data write clears pending", {7'd0, status[4]}, 8'h01);
    chk("R7 hold released", {7'd0, scl_hold}, 8'h00);
    done_pulse();
    chk("R9 data byte while selected", {7'd0, status[4]}, 8'h00);
    dsr_pulse();
    bus(1'b1, 1'b1);

    // R9 every_addr = 1
    every_addr = 1'b1;
    bus(1'b1, 1'b0);
    addr_pulse(8'h10);
    done_pulse();
    chk("R9 every address releases", {7'd0, status[4]}, 8'h00);
    dsr_pulse();
    bus(1'b1, 1'b1);
    every_addr = 1'b0;

    // master, status writes, START gating
    swr(8'hF0);
    chk("R10 busy write ignored as slave", status, 8'hD0);
    swr(8'hF0);
    chk("R10 R12 busy write in master transmit", status, 8'hF0);
    done_pulse();
    chk("R6 master byte end pending", {7'd0, status[4]}, 8'h00);
    chk("R6 master irq", {7'd0, irq}, 8'h01);
    start_req = 1'b1; cyc(); start_req = 1'b0;
    chk("R11 START blocked while busy", {7'd0, start_go}, 8'h00);
    swr(8'hD0);
    chk("R12 upper nibble written", status, 8'hD0);
    start_req = 1'b1; cyc(); start_req = 1'b0;
    chk("R11 START granted when free", {7'd0, start_go}, 8'h01);
    rx_bit = 1'b1; rx_bit_stb = 1'b1; cyc(); rx_bit_stb = 1'b0;
    chk("R1 last bit captured 1", {7'd0, status[0]}, 8'h01);
    swr(8'hD0);
    chk("R12 low nibble read-only", {4'd0, status[3:0]}, 8'h01);
    rx_bit = 1'b0; rx_bit_stb = 1'b1; cyc(); rx_bit_stb = 1'b0;
    chk("R1 ACK reads 0", {7'd0, status[0]}, 8'h00);
    rx_bit = 1'b1; rx_bit_stb = 1'b1; cyc(); rx_bit_stb = 1'b0;
    dsr_pulse();
    chk("R1 cleared by data write", {7'd0, status[0]}, 8'h00);

    // R5 arbitration loss
    drive_high = 1'b1;
    bus(1'b0, 1'b1);
    bus(1'b0, 1'b0);
    bus(1'b1, 1'b0);
    chk("R5 arbitration flag", {7'd0, status[3]}, 8'h01);
    chk("R5 transmit cleared at once", {7'd0, status[6]}, 8'h00);
    chk("R5 master kept until byte end", {7'd0, status[7]}, 8'h01);
    drive_high = 1'b0;
    done_pulse();
    chk("R5 master cleared at byte end", {7'd0, status[7]}, 8'h00);
    bus(1'b0, 1'b0);
    bus(1'b0, 1'b1);
    bus(1'b1, 1'b1);

    // R8 / R10 disable
    bus(1'b1, 1'b0);
    chk("R10 busy before disable", {7'd0, status[5]}, 8'h01);
    enable = 1'b0; cyc();
    chk("R10 busy forced off", {7'd0, status[5]}, 8'h00);
    chk("R8 pending released by disable", {7'd0, status[4]}, 8'h01);
    chk("R7 no hold when disabled", {7'd0, scl_hold}, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule